// File: doc/BRIEF.md
# Crate Trigger Interface Busy Aggregator

This block sits in each readout crate between the trigger supervisor and the crate's front-end modules. Every cycle in which the trigger input is high, it delivers one registered trigger pulse to every front-end trigger line. It also raises an interrupt request toward the readout controller. The request stays up until the controller acknowledges it. A trigger that arrives while a request is still outstanding is kept in a saturating pending-event counter, so it is not lost.

The block drives one crate busy line back to the supervisor. That line is the OR of two things: a locally held busy flag, and the busy lines of the front-end modules that are enabled in a mask register. The local flag comes up set after reset. The controller changes it with explicit commands. The controller talks to the block through a one-cycle write strobe that carries a 3-bit command code and a data word. The data word is used only when writing the enable mask.

Top module: `crate_trig_busy`

## Requirements
- R1: After reset the local busy flag is 1, the enable mask is all ones, the interrupt request is 0, the pending counter is 0 and all front-end trigger lines are 0.
- R2: `busy_o` equals the local busy flag ORed with every `fee_busy_i` bit whose mask bit is 1. It follows `fee_busy_i` in the same cycle, with no register on that path.
- R3: `busy_o` is low only when the local flag has been cleared and every enabled front-end busy line is low.
- R4: When `trig_in` is high in a cycle, all bits of `fee_trig_o` are 1 in the following cycle. When `trig_in` is low, all bits are 0 in the following cycle.
- R5: When `trig_in` is high while `irq_o` is low, `irq_o` is high in the next cycle.
- R6: A command strobe with code 1 sets the local busy flag, and code 2 clears it. The effect is visible from the next cycle.
- R7: `irq_o` stays high until an acknowledge (code 3) arrives. An acknowledge while the counter is 0 drops `irq_o` in the next cycle. An acknowledge while `irq_o` is low has no effect.
- R8: While `irq_o` is high:
  - a trigger without an acknowledge adds one to `pend_cnt_o`;
  - an acknowledge without a trigger subtracts one from a non-zero counter and keeps `irq_o` high;
  - a trigger together with an acknowledge leaves both unchanged.

  While `irq_o` is low, the counter is 0.
- R9: Code 4 loads the enable mask from `cmd_data`. Bit i set to 1 lets `fee_busy_i[i]` reach `busy_o`. Bit i set to 0 hides that line.
- R10: The pending counter saturates at 2^CNT_W-1. Further triggers with no acknowledge leave it there.
- R11: Command codes 0, 5, 6 and 7, and any code without the strobe, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger from the supervisor, one event per high cycle |
| fee_busy_i | input | N_FEE | Busy lines of the front-end modules |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command code (1 set busy, 2 clear busy, 3 acknowledge, 4 mask write) |
| cmd_data | input | N_FEE | Mask value for code 4 |
| fee_trig_o | output | N_FEE | Trigger fan-out, one line per front-end module |
| irq_o | output | 1 | Interrupt request to the readout controller |
| pend_cnt_o | output | CNT_W | Events waiting behind the current request |
| busy_o | output | 1 | Crate busy toward the supervisor |

## Verification
Several properties are checked on every cycle:
- a trigger yields a full fan-out word one cycle later;
- an idle request rises on a trigger;
- a raised request holds until acknowledged;
- the counter is zero whenever no request is up;
- a saturated counter stays saturated;
- at most one command event is decoded at a time.

Other behaviour can only be shown by the bench's scenarios, where its cycle model is compared on every clock:
- the exact counter value after interleaved triggers and acknowledges;
- masking of individual busy lines;
- the no-effect cases for undefined codes.

// File: rtl/ctbi_pkg.sv
package ctbi_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_SET_BUSY = 3'd1,
    CMD_CLR_BUSY = 3'd2,
    CMD_IRQ_ACK  = 3'd3,
    CMD_MASK_WR  = 3'd4
  } cmd_e;

  // Next value of the request flag given its state, whether events
  // are queued behind it, and this cycle's trigger and acknowledge.
  function automatic logic irq_flag_next(input logic irq, input logic cnt_nz,
                                         input logic trig, input logic ack);
    if (!irq) return trig;
    if (ack && !trig && !cnt_nz) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/ctbi_cmd_decode.sv
module ctbi_cmd_decode
  import ctbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       set_ev,
  output logic       clr_ev,
  output logic       ack_ev,
  output logic       mask_ev
);

  cmd_e code_e;

  always_comb begin
    code_e  = cmd_e'(cmd_code);
    set_ev  = 1'b0;
    clr_ev  = 1'b0;
    ack_ev  = 1'b0;
    mask_ev = 1'b0;
    if (cmd_valid) begin
      case (code_e)
        CMD_SET_BUSY: set_ev  = 1'b1;
        CMD_CLR_BUSY: clr_ev  = 1'b1;
        CMD_IRQ_ACK:  ack_ev  = 1'b1;
        CMD_MASK_WR:  mask_ev = 1'b1;
        default: ;
      endcase
    end
  end

  // R11: at most one event per strobe, none for undefined codes
  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_ev, clr_ev, ack_ev, mask_ev}));

  p_undef_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == 3'd0 || cmd_code > 3'd4)) |->
      !(set_ev || clr_ev || ack_ev || mask_ev));

endmodule

// File: rtl/ctbi_busy_merge.sv
module ctbi_busy_merge #(
  parameter int N_FEE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ev,
  input  logic             clr_ev,
  input  logic             mask_ev,
  input  logic [N_FEE-1:0] mask_data,
  input  logic [N_FEE-1:0] fee_busy_i,
  output logic             local_busy,
  output logic             fee_busy_any,
  output logic             busy_o
);

  logic             local_q;
  logic [N_FEE-1:0] mask_q;
  logic [N_FEE-1:0] gated;

  function automatic logic masked_any(input logic [N_FEE-1:0] lines,
                                      input logic [N_FEE-1:0] en);
    return |(lines & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_q <= 1'b1;
      mask_q  <= '1;
    end else begin
      if (set_ev)      local_q <= 1'b1;
      else if (clr_ev) local_q <= 1'b0;
      if (mask_ev)     mask_q  <= mask_data;
    end
  end

  for (genvar i = 0; i < N_FEE; i++) begin : g_gate
    assign gated[i] = fee_busy_i[i] & mask_q[i];
  end

  assign local_busy   = local_q;
  assign fee_busy_any = masked_any(fee_busy_i, mask_q);
  assign busy_o       = local_q | fee_busy_any;

  // R6: set and clear commands land on the next cycle
  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> (local_q && busy_o));
  p_clr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !local_q);
  // R3: any enabled front-end busy keeps the crate busy
  p_fee_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|gated) |-> busy_o);
  // R9: mask load visible next cycle
  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ev |=> (mask_q == $past(mask_data)));

endmodule

// File: rtl/ctbi_trig_fanout.sv
module ctbi_trig_fanout #(
  parameter int N_FEE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  output logic [N_FEE-1:0] fee_trig_o
);

  for (genvar i = 0; i < N_FEE; i++) begin : g_line
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= trig_in;
    end
    assign fee_trig_o[i] = q;
  end

  // R4: full word one cycle after a trigger, quiet otherwise
  p_fan_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_in |=> (&fee_trig_o));
  p_fan_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_in |=> (fee_trig_o == '0));

endmodule

// File: rtl/ctbi_irq_track.sv
module ctbi_irq_track
  import ctbi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             ack_ev,
  output logic             irq_o,
  output logic [CNT_W-1:0] pend_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             queue_ev;
  logic             drain_ev;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    if (up && c != CNT_MAX) return c + 1'b1;
    if (dn && c != '0)      return c - 1'b1;
    return c;
  endfunction

  assign queue_ev = irq_q && trig_in && !ack_ev;
  assign drain_ev = irq_q && ack_ev && !trig_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      irq_q <= irq_flag_next(irq_q, cnt_q != '0, trig_in, ack_ev);
      cnt_q <= cnt_next(cnt_q, queue_ev, drain_ev);
    end
  end

  assign irq_o      = irq_q;
  assign pend_cnt_o = cnt_q;

  // R5: an idle request rises on a trigger
  p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && !irq_q) |=> irq_q);
  // R7: a raised request holds until acknowledged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack_ev) |=> irq_q);
  // R8: no events counted without a request
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (cnt_q == '0));
  // R8: queued trigger below the limit raises the count by one
  p_queue_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_ev && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10: saturated counter stays saturated
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !ack_ev) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/crate_trig_busy.sv
module crate_trig_busy #(
  parameter int N_FEE = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic [N_FEE-1:0] fee_busy_i,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [N_FEE-1:0] cmd_data,
  output logic [N_FEE-1:0] fee_trig_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] pend_cnt_o,
  output logic             busy_o
);

  logic set_ev, clr_ev, ack_ev, mask_ev;
  logic local_busy, fee_busy_any;

  ctbi_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .set_ev(set_ev), .clr_ev(clr_ev), .ack_ev(ack_ev), .mask_ev(mask_ev)
  );

  ctbi_busy_merge #(.N_FEE(N_FEE)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .mask_ev(mask_ev), .mask_data(cmd_data), .fee_busy_i(fee_busy_i),
    .local_busy(local_busy), .fee_busy_any(fee_busy_any), .busy_o(busy_o)
  );

  ctbi_trig_fanout #(.N_FEE(N_FEE)) u_fan (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .fee_trig_o(fee_trig_o)
  );

  ctbi_irq_track #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ack_ev(ack_ev),
    .irq_o(irq_o), .pend_cnt_o(pend_cnt_o)
  );

  // R3: crate free only when both sources are free
  p_free_means_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!local_busy && !fee_busy_any));
  // R7: acknowledge of last event drops the request next cycle
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_ev && !trig_in && pend_cnt_o == '0) |=> !irq_o);

endmodule

// File: tb/crate_trig_busy_tb_top.sv
module crate_trig_busy_tb_top;

  localparam int NF   = 4;
  localparam int CW   = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_in = 1'b0;
  logic [NF-1:0] fee_busy_i = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_code = '0;
  logic [NF-1:0] cmd_data = '0;
  logic [NF-1:0] fee_trig_o;
  logic          irq_o;
  logic [CW-1:0] pend_cnt_o;
  logic          busy_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural model state
  bit          m_local = 1'b1;
  bit [NF-1:0] m_mask = '1;
  bit          m_irq = 1'b0;
  int          m_cnt = 0;
  bit          m_trig = 1'b0;

  always #2.5 clk = ~clk;

  crate_trig_busy #(.N_FEE(NF), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .fee_busy_i(fee_busy_i),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .fee_trig_o(fee_trig_o), .irq_o(irq_o), .pend_cnt_o(pend_cnt_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit exp_busy;
    exp_busy = m_local || ((fee_busy_i & m_mask) != '0);
    chk(tag, "busy_o", int'(busy_o), int'(exp_busy));
    chk(tag, "fee_trig_o", int'(fee_trig_o), m_trig ? (1 << NF) - 1 : 0);
    chk(tag, "irq_o", int'(irq_o), int'(m_irq));
    chk(tag, "pend_cnt_o", int'(pend_cnt_o), m_cnt);
  endtask

  // one clock: drive, check, let the edge happen, update model
  task automatic cyc(input string tag, input bit t, input bit [NF-1:0] fb,
                     input bit v, input bit [2:0] c, input bit [NF-1:0] d);
    bit ack;
    trig_in = t; fee_busy_i = fb; cmd_valid = v; cmd_code = c; cmd_data = d;
    #1;
    compare(tag);
    @(posedge clk);
    ack = 1'b0;
    if (v) begin
      case (c)
        3'd1: m_local = 1'b1;
        3'd2: m_local = 1'b0;
        3'd3: ack = 1'b1;
        3'd4: m_mask = d;
        default: ;
      endcase
    end
    if (!m_irq) begin
      m_irq = t;
    end else if (t && !ack) begin
      if (m_cnt < MAXC) m_cnt++;
    end else if (ack && !t) begin
      if (m_cnt > 0) m_cnt--;
      else m_irq = 1'b0;
    end
    m_trig = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");                 // reset state held during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 / R3: local busy dominates, then clears
    cyc("R2", 0, 4'b0000, 0, 3'd0, '0);
    cyc("R6", 0, 4'b0101, 1, 3'd2, '0);   // clear local busy
    cyc("R3", 0, 4'b0101, 0, 3'd0, '0);   // front-end still busy
    cyc("R3", 0, 4'b0000, 0, 3'd0, '0);   // all clear -> low
    cyc("R2", 0, 4'b1000, 0, 3'd0, '0);
    cyc("R6", 0, 4'b0000, 1, 3'd1, '0);   // set local busy
    cyc("R6", 0, 4'b0000, 1, 3'd2, '0);
    cyc("R6", 0, 4'b0000, 0, 3'd0, '0);

    // R9: mask hides lines 0 and 2
    cyc("R9", 0, 4'b0000, 1, 3'd4, 4'b1010);
    cyc("R9", 0, 4'b0101, 0, 3'd0, '0);
    cyc("R9", 0, 4'b0010, 0, 3'd0, '0);
    cyc("R9", 0, 4'b0000, 1, 3'd4, 4'b1111);

    // R11: undefined codes and unstrobed codes do nothing
    cyc("R11", 0, 4'b0000, 1, 3'd0, 4'b0000);
    cyc("R11", 0, 4'b0000, 1, 3'd5, 4'b0000);
    cyc("R11", 0, 4'b0000, 1, 3'd6, 4'b0000);
    cyc("R11", 0, 4'b0000, 1, 3'd7, 4'b0000);
    cyc("R11", 0, 4'b0000, 0, 3'd1, 4'b0000);
    cyc("R11", 0, 4'b0000, 0, 3'd4, 4'b0000);
    cyc("R11", 0, 4'b0001, 0, 3'd0, '0);    // mask intact, local still clear

    // R7: ack with no request ignored
    cyc("R7", 0, 4'b0000, 1, 3'd3, '0);
    // R4 / R5: trigger fans out, request rises
    cyc("R5", 1, 4'b0000, 0, 3'd0, '0);
    cyc("R4", 0, 4'b0000, 0, 3'd0, '0);
    cyc("R7", 0, 4'b0000, 0, 3'd0, '0);
    // R8: queue three, ack with trigger same cycle, drain
    cyc("R8", 1, 4'b0000, 0, 3'd0, '0);
    cyc("R8", 1, 4'b0000, 0, 3'd0, '0);
    cyc("R8", 1, 4'b0000, 0, 3'd0, '0);
    cyc("R8", 1, 4'b0000, 1, 3'd3, '0);
    cyc("R8", 0, 4'b0000, 1, 3'd3, '0);
    cyc("R8", 0, 4'b0000, 1, 3'd3, '0);
    cyc("R8", 0, 4'b0000, 1, 3'd3, '0);
    cyc("R7", 0, 4'b0000, 1, 3'd3, '0);     // last ack drops request
    cyc("R7", 0, 4'b0000, 0, 3'd0, '0);

    // R10: saturate the counter
    for (int i = 0; i < MAXC + 4; i++) cyc("R10", 1, 4'b0000, 0, 3'd0, '0);
    cyc("R10", 0, 4'b0000, 0, 3'd0, '0);
    for (int i = 0; i < MAXC + 2; i++) cyc("R8", 0, 4'b0000, 1, 3'd3, '0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      bit [2:0] c;
      c = 3'($urandom_range(0, 7));
      cyc("R2", 1'($urandom_range(0, 2) == 0), NF'($urandom), 1'($urandom_range(0, 1)),
          c, NF'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule